// File: doc/BRIEF.md
# Radial Distortion Coordinate Pipeline

This block turns a raster-order video timing stream into corrected source coordinates for barrel lens correction. Every visible pixel yields one result: the pixel position measured from the optical centre and scaled by a magnification factor. The factor depends on the squared distance from the centre.

Inside, the block keeps signed x and y counters and running squares of both. The squares are updated by adding odd increments, so no multiplier is needed for them. The squared radius is multiplied by a programmable coefficient. The product then indexes an interpolated magnification table, and the delayed x and y are scaled by the interpolated factor.

A downstream pixel fetcher consumes the results at one per clock after a fixed latency. Source pixel fetch and pixel-value interpolation belong to that consumer, not to this block.

Top module: `radial_warp_gen`

## Requirements
- R1: Reset clears `valid_o` and puts the position trackers at (X_START, Y_START). The first visible pixel after reset is reported at that position, even when no frame-start pulse has been given.
- R2: Each visible pixel that is not a row end advances x by one for the next pixel. The running x² stays equal to x·x through additions only.
- R3: A visible pixel flagged as row end moves the next pixel to x = X_START and y + 1. The running y² stays equal to y·y.
- R4: A frame-start pulse (`sof_i`) returns the trackers to (X_START, Y_START) from any state, including the middle of a row, and takes priority over `vis_i` and `eol_i`.
- R5: A cycle with `vis_i` low moves no tracker and produces no valid result.
- R6: With rk = (x² + y²)·k, the table index is rk bits [RK_SHIFT+FRAC_W +: IDX_W] and the fraction is rk bits [RK_SHIFT +: FRAC_W]. mag = T[i] + floor((T[i+1] − T[i])·f / 2^FRAC_W). Entry n of the table occupies bits [16n +: MAG_W] of MAG_TBL.
- R7: When rk ≥ 2^(RK_SHIFT+IDX_W+FRAC_W), mag saturates to the last entry T[2^IDX_W].
- R8: `cx_o` = floor(mag·x / 2^MAG_FRAC) and `cy_o` = floor(mag·y / 2^MAG_FRAC), both signed and COORD_W + MAG_W − MAG_FRAC bits wide.
- R9: The pipeline gives one result per clock. `valid_o` rises exactly 5 clock edges after the edge that samples a visible pixel, and that result belongs to that pixel.
- R10: `k_i` is sampled together with its pixel, so changing it on every pixel gives each result the coefficient that pixel carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vis_i | input | 1 | Current cycle carries a visible pixel |
| eol_i | input | 1 | Visible pixel is the last one of its row |
| sof_i | input | 1 | Frame start, restarts the position trackers |
| k_i | input | K_W | Unsigned distortion coefficient |
| cx_o | output | COORD_W+MAG_W−MAG_FRAC | Corrected x, signed |
| cy_o | output | COORD_W+MAG_W−MAG_FRAC | Corrected y, signed |
| valid_o | output | 1 | `cx_o`/`cy_o` hold a result |

## Verification
The bench drives every pixel of small frames and compares each result with arithmetic done in the bench. It uses a non-linear table, so an off-by-one index or a truncated fraction shows up as wrong coordinates. A coefficient of zero yields unit magnification, so a tracker that mis-steps its squares or misses a row wrap is exposed directly. A coefficient of 255 drives most pixels into saturation, which catches a wrapped index. Gaps inside rows, a restart mid-row and a coefficient changed on every pixel check that idle cycles do not advance the trackers and that x, y and k stay aligned with their magnification. A wrong delay would show up as outputs belonging to a neighbouring pixel, and a wrong valid chain as results that are missing or emitted twice.

// File: rtl/radwarp_pkg.sv
`timescale 1ns/1ps
package radwarp_pkg;
  localparam int unsigned TBL_SLOT_W = 16;
  localparam int unsigned TBL_CAP    = 65;
  typedef logic [TBL_CAP*TBL_SLOT_W-1:0] mag_tbl_t;

  // ramp table: entry i = one + i*step, for i < n
  function automatic mag_tbl_t linear_tbl(int unsigned n, int unsigned one, int unsigned step);
    mag_tbl_t t;
    t = '0;
    for (int unsigned i = 0; i < TBL_CAP; i++) begin
      if (i < n) t[i*TBL_SLOT_W +: TBL_SLOT_W] = TBL_SLOT_W'(one + i*step);
    end
    return t;
  endfunction
endpackage

// File: rtl/pipe_delay.sv
`timescale 1ns/1ps
module pipe_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/coord_tracker.sv
`timescale 1ns/1ps
module coord_tracker #(
  parameter int unsigned COORD_W = 8,
  parameter int          X_START = -8,
  parameter int          Y_START = -6,
  localparam int unsigned SQ_W   = 2*COORD_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vis_i,
  input  logic                      eol_i,
  input  logic                      sof_i,
  output logic signed [COORD_W-1:0] x_o,
  output logic signed [COORD_W-1:0] y_o,
  output logic [SQ_W-1:0]           sx_o,
  output logic [SQ_W-1:0]           sy_o
);
  localparam logic signed [COORD_W-1:0] X0 = COORD_W'(X_START);
  localparam logic signed [COORD_W-1:0] Y0 = COORD_W'(Y_START);
  localparam logic [SQ_W-1:0] X0_SQ = SQ_W'(X_START*X_START);
  localparam logic [SQ_W-1:0] Y0_SQ = SQ_W'(Y_START*Y_START);
  localparam int unsigned EW = SQ_W + 2;

  logic signed [EW-1:0] sx_nxt, sy_nxt;

  // square of (v+1) = square of v + 2v + 1
  always_comb begin
    sx_nxt = $signed({2'b00, sx_o}) + (EW'(x_o) <<< 1) + EW'(1);
    sy_nxt = $signed({2'b00, sy_o}) + (EW'(y_o) <<< 1) + EW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o <= X0; sx_o <= X0_SQ; y_o <= Y0; sy_o <= Y0_SQ;
    end else if (sof_i) begin
      x_o <= X0; sx_o <= X0_SQ; y_o <= Y0; sy_o <= Y0_SQ;
    end else if (vis_i) begin
      if (eol_i) begin
        x_o  <= X0;
        sx_o <= X0_SQ;
        y_o  <= y_o + COORD_W'(1);
        sy_o <= sy_nxt[SQ_W-1:0];
      end else begin
        x_o  <= x_o + COORD_W'(1);
        sx_o <= sx_nxt[SQ_W-1:0];
      end
    end
  end

  a_r2_sx_square: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sx_o == SQ_W'(int'(x_o) * int'(x_o)));
  a_r3_sy_square: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sy_o == SQ_W'(int'(y_o) * int'(y_o)));
  a_r2_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_i && !eol_i && !sof_i |=> x_o == $past(x_o) + COORD_W'(1) && $stable(y_o));
  a_r3_row_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_i && eol_i && !sof_i |=> x_o == X0 && y_o == $past(y_o) + COORD_W'(1));
  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> x_o == X0 && y_o == Y0);
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vis_i && !sof_i |=> $stable(x_o) && $stable(y_o));
endmodule

// File: rtl/mag_lookup.sv
`timescale 1ns/1ps
module mag_lookup
  import radwarp_pkg::*;
#(
  parameter int unsigned RK_W     = 25,
  parameter int unsigned RK_SHIFT = 4,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned FRAC_W   = 4,
  parameter int unsigned MAG_W    = 12,
  parameter mag_tbl_t    MAG_TBL  = linear_tbl((1 << IDX_W) + 1, 1024, 32)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RK_W-1:0]  rk_i,
  output logic [MAG_W-1:0] mag_o
);
  localparam int unsigned LAST = 1 << IDX_W;
  localparam int unsigned PW   = MAG_W + FRAC_W + 2;

  function automatic logic [MAG_W-1:0] ent(int unsigned i);
    return MAG_TBL[i*TBL_SLOT_W +: MAG_W];
  endfunction

  logic [RK_W-1:0]   rk_sh;
  logic              sat;
  logic [IDX_W-1:0]  idx;
  logic [FRAC_W-1:0] frac;
  logic [MAG_W-1:0]  base_q, nxt_q, lo, hi;
  logic [FRAC_W-1:0] frac_q;
  logic signed [PW-1:0] diff, prod, sum;

  always_comb begin
    rk_sh = rk_i >> RK_SHIFT;
    sat   = (rk_sh >> (IDX_W + FRAC_W)) != '0;
    frac  = rk_sh[FRAC_W-1:0];
    idx   = rk_sh[FRAC_W +: IDX_W];
  end

  // stage A: fetch the two neighbouring entries
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0; nxt_q <= '0; frac_q <= '0;
    end else if (sat) begin
      base_q <= ent(LAST); nxt_q <= ent(LAST); frac_q <= '0;
    end else begin
      base_q <= ent(32'(idx)); nxt_q <= ent(32'(idx) + 1); frac_q <= frac;
    end
  end

  // stage B: linear blend, floor rounding
  always_comb begin
    diff = PW'($signed({1'b0, nxt_q})) - PW'($signed({1'b0, base_q}));
    prod = diff * PW'($signed({1'b0, frac_q}));
    sum  = PW'($signed({1'b0, base_q})) + (prod >>> FRAC_W);
    lo   = (base_q < nxt_q) ? base_q : nxt_q;
    hi   = (base_q < nxt_q) ? nxt_q : base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mag_o <= '0;
    else         mag_o <= sum[MAG_W-1:0];
  end

  a_r6_mag_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mag_o >= $past(lo) && mag_o <= $past(hi));
  a_r7_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat |=> ##1 mag_o == ent(LAST));
endmodule

// File: rtl/radial_warp_gen.sv
`timescale 1ns/1ps
module radial_warp_gen
  import radwarp_pkg::*;
#(
  parameter int unsigned COORD_W  = 8,
  parameter int          X_START  = -64,
  parameter int          Y_START  = -48,
  parameter int unsigned K_W      = 8,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned FRAC_W   = 4,
  parameter int unsigned RK_SHIFT = 8,
  parameter int unsigned MAG_W    = 12,
  parameter int unsigned MAG_FRAC = 10,
  parameter mag_tbl_t    MAG_TBL  = linear_tbl((1 << IDX_W) + 1, 1024, 32),
  localparam int unsigned OUT_W   = COORD_W + MAG_W - MAG_FRAC
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vis_i,
  input  logic                    eol_i,
  input  logic                    sof_i,
  input  logic [K_W-1:0]          k_i,
  output logic signed [OUT_W-1:0] cx_o,
  output logic signed [OUT_W-1:0] cy_o,
  output logic                    valid_o
);
  localparam int unsigned SQ_W = 2*COORD_W;
  localparam int unsigned R2_W = SQ_W + 1;
  localparam int unsigned RK_W = R2_W + K_W;
  localparam int unsigned PX_W = MAG_W + COORD_W + 1;
  localparam int unsigned XY_DLY = 4;  // aligns x,y with mag register
  localparam int unsigned LAT    = 5;

  logic signed [COORD_W-1:0] x_c, y_c;
  logic [SQ_W-1:0]   sx_c, sy_c;
  logic [R2_W-1:0]   r2_q;
  logic [K_W-1:0]    k1_q;
  logic [RK_W-1:0]   rk_q;
  logic [MAG_W-1:0]  mag_c;
  logic [2*COORD_W-1:0] xy_d;
  logic              v_d;
  logic signed [COORD_W-1:0] xd, yd;
  logic signed [PX_W-1:0] px, py;

  coord_tracker #(.COORD_W(COORD_W), .X_START(X_START), .Y_START(Y_START)) u_trk (
    .clk_i, .rst_ni, .vis_i, .eol_i, .sof_i,
    .x_o(x_c), .y_o(y_c), .sx_o(sx_c), .sy_o(sy_c));

  // stage 1: radius squared, coefficient captured with its pixel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r2_q <= '0; k1_q <= '0; rk_q <= '0;
    end else begin
      r2_q <= R2_W'(sx_c) + R2_W'(sy_c);
      k1_q <= k_i;
      rk_q <= RK_W'(r2_q) * RK_W'(k1_q);  // stage 2
    end
  end

  mag_lookup #(.RK_W(RK_W), .RK_SHIFT(RK_SHIFT), .IDX_W(IDX_W), .FRAC_W(FRAC_W),
               .MAG_W(MAG_W), .MAG_TBL(MAG_TBL)) u_lut (
    .clk_i, .rst_ni, .rk_i(rk_q), .mag_o(mag_c));

  pipe_delay #(.W(2*COORD_W), .DEPTH(XY_DLY)) u_xy_dly (
    .clk_i, .rst_ni, .d_i({x_c, y_c}), .q_o(xy_d));
  pipe_delay #(.W(1), .DEPTH(LAT - 1)) u_v_dly (
    .clk_i, .rst_ni, .d_i(vis_i), .q_o(v_d));

  always_comb begin
    xd = $signed(xy_d[2*COORD_W-1:COORD_W]);
    yd = $signed(xy_d[COORD_W-1:0]);
    px = PX_W'($signed({1'b0, mag_c})) * PX_W'(xd);
    py = PX_W'($signed({1'b0, mag_c})) * PX_W'(yd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cx_o <= '0; cy_o <= '0; valid_o <= 1'b0;
    end else begin
      cx_o    <= OUT_W'(px >>> MAG_FRAC);
      cy_o    <= OUT_W'(py >>> MAG_FRAC);
      valid_o <= v_d;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_i |-> ##5 valid_o);
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vis_i |-> ##5 !valid_o);
endmodule

// File: tb/radial_warp_gen_test.sv
`timescale 1ns/1ps
module radial_warp_gen_test;
  localparam int X0 = -8;
  localparam int Y0 = -6;
  localparam int ROW = 16;
  localparam int ROWS = 12;

  function automatic radwarp_pkg::mag_tbl_t tb_tbl();
    radwarp_pkg::mag_tbl_t t;
    t = '0;
    for (int i = 0; i < 17; i++) t[i*16 +: 16] = 16'(1024 + 3*i*i);
    return t;
  endfunction
  localparam radwarp_pkg::mag_tbl_t TBL = tb_tbl();

  logic clk = 1'b0, rst_n = 1'b0, vis = 1'b0, eol = 1'b0, sof = 1'b0;
  logic [7:0] k = '0;
  logic signed [9:0] cx, cy;
  logic valid;

  radial_warp_gen #(.COORD_W(8), .X_START(X0), .Y_START(Y0), .K_W(8), .IDX_W(4),
    .FRAC_W(4), .RK_SHIFT(4), .MAG_W(12), .MAG_FRAC(10), .MAG_TBL(TBL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .vis_i(vis), .eol_i(eol), .sof_i(sof), .k_i(k),
    .cx_o(cx), .cy_o(cy), .valid_o(valid));

  always #2.5 clk = ~clk;

  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int tx = X0, ty = Y0;
  string next_tag = "R1";
  int q_due[$], q_x[$], q_y[$];
  string q_tag[$];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  function automatic int ent(int i);
    return 1024 + 3*i*i;
  endfunction

  function automatic int mag_of(int rk);
    int i, f;
    if (rk >= 4096) return ent(16);
    i = (rk >> 8) & 15;
    f = (rk >> 4) & 15;
    return ent(i) + (((ent(i+1) - ent(i)) * f) >>> 4);
  endfunction

  task automatic check_out();
    bit ev;
    ev = (q_due.size() > 0) && (q_due[0] == cyc);
    n_chk++;
    if (valid !== ev) begin
      n_bad++;
      $display("FAIL %s valid_o=%0b expected %0b at cycle %0d", ev ? "R9" : "R5", valid, ev, cyc);
    end
    if (ev) begin
      n_chk++;
      if (int'(cx) != q_x[0] || int'(cy) != q_y[0]) begin
        n_bad++;
        $display("FAIL %s coord=(%0d,%0d) expected (%0d,%0d)", q_tag[0], cx, cy, q_x[0], q_y[0]);
      end
      void'(q_due.pop_front()); void'(q_x.pop_front());
      void'(q_y.pop_front()); void'(q_tag.pop_front());
    end
  endtask

  task automatic step(bit v, bit e, bit s, int kv, string extra);
    int rk, m;
    @(negedge clk);
    check_out();
    vis = v; eol = e; sof = s; k = 8'(kv);
    if (s) begin
      tx = X0; ty = Y0; next_tag = "R4";
    end else if (v) begin
      rk = (tx*tx + ty*ty) * kv;
      m = mag_of(rk);
      q_due.push_back(cyc + 5);
      q_x.push_back((m*tx) >>> 10);
      q_y.push_back((m*ty) >>> 10);
      q_tag.push_back({next_tag, "/", (rk >= 4096) ? "R7" : "R6", "/R8", extra});
      if (e) begin tx = X0; ty = ty + 1; next_tag = "R3"; end
      else begin tx = tx + 1; next_tag = "R2"; end
    end
  endtask

  // kmode < 0: coefficient alternates per pixel (R10)
  task automatic run_frame(bit with_sof, int kmode, bit gaps, int npix);
    int kv;
    if (with_sof) step(1'b0, 1'b0, 1'b1, 0, "");
    for (int p = 0; p < npix; p++) begin
      kv = (kmode < 0) ? ((p % 2) ? 200 : 40) : kmode;
      if (gaps && (p % 5 == 2)) step(1'b0, 1'b0, 1'b0, kv, "");
      step(1'b1, (p % ROW) == ROW - 1, 1'b0, kv, (kmode < 0) ? "/R10" : "");
      if ((p % ROW) == ROW - 1) begin
        step(1'b0, 1'b0, 1'b0, 0, "");
        step(1'b0, 1'b0, 1'b0, 0, "");
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (valid !== 1'b0) begin n_bad++; $display("FAIL R1 valid_o=%0b expected 0", valid); end
    run_frame(1'b0, 40, 1'b0, ROW*ROWS);   // R1 start without sof
    run_frame(1'b1, 0, 1'b1, ROW*ROWS);    // unity mag, gaps: R2 R3 R5
    run_frame(1'b1, 255, 1'b0, ROW*ROWS);  // saturation R7
    run_frame(1'b1, 17, 1'b1, 40);         // partial frame, then restart mid-row R4
    run_frame(1'b1, -1, 1'b0, ROW*ROWS);   // per-pixel coefficient R10
    run_frame(1'b1, 90, 1'b1, ROW*ROWS);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0, 0, "");
    n_chk++;
    if (q_due.size() != 0) begin
      n_bad++;
      $display("FAIL R9 pending=%0d expected 0", q_due.size());
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule